// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the multiply and accumulate engine of a 32-bit fixed-point core. Each accepted operation carries two 32-bit operands (`opa`, `opb`) and an accumulator input made of two 32-bit words (`acc_hi`, `acc_lo`). A 4-bit opcode selects one of twelve operations, and the block returns a 64-bit result word. Operations with a 32-bit result place it in the low half and zero the high half. The block does no rounding. Accumulation carries no guard bits, so sums wrap modulo 2^32 or 2^64, with one exception: a signed 16x16 product added into a 64-bit accumulator has 32 guard bits above the product.

Opcodes 0, 1 and 2 form the full-width product with a 32-bit result. They are multiply, multiply-add (adds `acc_lo`) and multiply-accumulate (adds the low word of the previously produced result). Opcodes 3 and 4 are 64-bit multiply and 64-bit multiply-accumulate. These two honour `is_signed` and use `{acc_hi, acc_lo}` as the addend. Opcodes 5, 6 and 7 form a signed 16x16 product from halves chosen by `sel_a_hi` and `sel_b_hi`, then apply the same three addend choices. Opcodes 8, 9 and 10 do the same for the signed 32x16 product, keeping bits 47..16 of the 48-bit product. Opcode 11 adds a sign-extended 16x16 product to the 64-bit accumulator input. Opcodes 12 to 15 are reserved.

Operations enter through a valid/ready handshake and leave two cycles later, in order. A stalled output holds the pipeline.

Top module: `mac_unit`

## Requirements
- R1: Opcode 0 returns the low 32 bits of `opa*opb`. This value is the same whether `is_signed` is 0 or 1.
- R2: Opcode 3 returns the full 64-bit product. The operands are two's complement when `is_signed`=1 and unsigned when it is 0.
- R3: Opcode 4 returns the 64-bit product (signedness set by `is_signed`) plus `{acc_hi,acc_lo}`, modulo 2^64.
- R4: Opcodes 1, 6 and 9 add `acc_lo` to their 32-bit product and keep the sum modulo 2^32, with no guard bits.
- R5: Opcodes 2, 7 and 10 add the low 32 bits of the most recently produced result (0 after reset) and keep the sum modulo 2^32.
- R6: Opcodes 5, 6 and 7 multiply two signed 16-bit halves. `sel_a_hi`/`sel_b_hi` = 1 selects bits 31..16 and 0 selects bits 15..0. `is_signed` is ignored.
- R7: Opcodes 8, 9 and 10 take bits 47..16 of the signed product of `opa` and the half of `opb` chosen by `sel_b_hi`. `sel_a_hi` and `is_signed` are ignored.
- R8: Opcode 11 returns the sign-extended signed 16x16 product (halves chosen as in R6) plus `{acc_hi,acc_lo}`, modulo 2^64.
- R9: For opcodes 0-2 and 5-10, `out_result[63:32]` is zero.
- R10: With `out_ready` high, an operation accepted at a clock edge appears on `out_valid`/`out_result` after the second following edge, for exactly one cycle. Results come out in issue order.
- R11: While `out_valid`=1 and `out_ready`=0, `out_result` and `out_valid` hold and `in_ready` is 0.
- R12: Opcodes 12-15 produce a valid result of zero.
- R13: Synchronous reset clears `out_valid` and sets the previous-result value to 0. After reset, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op | input | 4 | Operation code |
| is_signed | input | 1 | Two's complement operands for opcodes 3 and 4 |
| sel_a_hi | input | 1 | Take upper half of `opa` in 16x16 modes |
| sel_b_hi | input | 1 | Take upper half of `opb` in halfword modes |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_hi | input | 32 | Upper word of 64-bit accumulator input |
| acc_lo | input | 32 | Lower word / 32-bit addend |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer can take it |
| out_result | output | 64 | Result; upper word zero for 32-bit modes |

## Verification
The assertions check the handshake properties on every cycle. These are the two-stage progress of an accepted operation, the holding of a stalled result, the zero upper word of narrow results, and the 32-bit signed range of every 16x16 product. The arithmetic values themselves can only be shown by the bench. It sweeps every opcode, both signedness settings and all four half-select pairs over extreme operands such as 0x80000000 and 0x8000. It also covers chained accumulation through the previous result, and stall and latency timing.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned MAC_W = 32;

    typedef enum logic [3:0] {
        OP_MUL   = 4'd0,
        OP_MADD  = 4'd1,
        OP_MACC  = 4'd2,
        OP_MULL  = 4'd3,
        OP_MACL  = 4'd4,
        OP_HMUL  = 4'd5,
        OP_HMADD = 4'd6,
        OP_HMACC = 4'd7,
        OP_WMUL  = 4'd8,
        OP_WMADD = 4'd9,
        OP_WMACC = 4'd10,
        OP_HMACL = 4'd11
    } mac_op_e;

    typedef enum logic [1:0] {
        ADD_NONE   = 2'd0,
        ADD_ACC32  = 2'd1,
        ADD_PREV32 = 2'd2,
        ADD_ACC64  = 2'd3
    } addend_e;

    typedef enum logic [1:0] {
        SHP_FULL = 2'd0,
        SHP_HALF = 2'd1,
        SHP_WIDE = 2'd2,
        SHP_ZERO = 2'd3
    } shape_e;

    typedef struct packed {
        shape_e  shape;
        addend_e addend;
        logic    wide;
        logic    use_sign;
    } dec_t;

    typedef struct packed {
        logic                 valid;
        logic                 half;
        addend_e              addend;
        logic                 wide;
        logic [2*MAC_W-1:0]   prod;
        logic [2*MAC_W-1:0]   acc;
    } stage1_t;

    function automatic dec_t mac_decode(input logic [3:0] code);
        dec_t d;
        d = '{shape: SHP_ZERO, addend: ADD_NONE, wide: 1'b0, use_sign: 1'b0};
        case (code)
            OP_MUL:   d = '{SHP_FULL, ADD_NONE,   1'b0, 1'b0};
            OP_MADD:  d = '{SHP_FULL, ADD_ACC32,  1'b0, 1'b0};
            OP_MACC:  d = '{SHP_FULL, ADD_PREV32, 1'b0, 1'b0};
            OP_MULL:  d = '{SHP_FULL, ADD_NONE,   1'b1, 1'b1};
            OP_MACL:  d = '{SHP_FULL, ADD_ACC64,  1'b1, 1'b1};
            OP_HMUL:  d = '{SHP_HALF, ADD_NONE,   1'b0, 1'b0};
            OP_HMADD: d = '{SHP_HALF, ADD_ACC32,  1'b0, 1'b0};
            OP_HMACC: d = '{SHP_HALF, ADD_PREV32, 1'b0, 1'b0};
            OP_WMUL:  d = '{SHP_WIDE, ADD_NONE,   1'b0, 1'b0};
            OP_WMADD: d = '{SHP_WIDE, ADD_ACC32,  1'b0, 1'b0};
            OP_WMACC: d = '{SHP_WIDE, ADD_PREV32, 1'b0, 1'b0};
            OP_HMACL: d = '{SHP_HALF, ADD_ACC64,  1'b1, 1'b0};
            default:  d = '{SHP_ZERO, ADD_NONE,   1'b0, 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mac_opnd_sel.sv
module mac_opnd_sel
    import mac_pkg::*;
#(
    parameter int unsigned W = MAC_W
) (
    input  shape_e             shape,
    input  logic               use_sign,
    input  logic               sel_a_hi,
    input  logic               sel_b_hi,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic signed [W:0]  xa,
    output logic signed [W:0]  xb
);
    localparam int unsigned H = W / 2;

    logic [H-1:0] half_a;
    logic [H-1:0] half_b;

    assign half_a = sel_a_hi ? a[W-1:H] : a[H-1:0];
    assign half_b = sel_b_hi ? b[W-1:H] : b[H-1:0];

    always_comb begin
        case (shape)
            SHP_FULL: begin
                xa = {use_sign & a[W-1], a};
                xb = {use_sign & b[W-1], b};
            end
            SHP_HALF: begin
                xa = {{(H+1){half_a[H-1]}}, half_a};
                xb = {{(H+1){half_b[H-1]}}, half_b};
            end
            SHP_WIDE: begin
                xa = {a[W-1], a};
                xb = {{(H+1){half_b[H-1]}}, half_b};
            end
            default: begin
                xa = '0;
                xb = '0;
            end
        endcase
    end

endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int unsigned W = MAC_W
) (
    input  shape_e               shape,
    input  logic signed [W:0]    xa,
    input  logic signed [W:0]    xb,
    output logic [2*W-1:0]       prod
);
    localparam int unsigned H  = W / 2;
    localparam int unsigned PW = 2 * W;

    logic signed [PW-1:0] full;

    assign full = PW'(xa) * PW'(xb);

    always_comb begin
        case (shape)
            SHP_FULL, SHP_HALF: prod = full;
            SHP_WIDE:           prod = {{(PW-W){full[W+H-1]}}, full[W+H-1:H]};
            default:            prod = '0;
        endcase
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int unsigned W = MAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_v,
    input  addend_e           addend,
    input  logic              wide,
    input  logic [2*W-1:0]    prod,
    input  logic [2*W-1:0]    acc,
    output logic              res_v,
    output logic [2*W-1:0]    res
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] res_q;
    logic          v_q;
    logic          wide_q;
    logic [PW-1:0] add_sel;
    logic [PW-1:0] sum;

    always_comb begin
        case (addend)
            ADD_ACC32:  add_sel = {{(PW-W){1'b0}}, acc[W-1:0]};
            ADD_PREV32: add_sel = {{(PW-W){1'b0}}, res_q[W-1:0]};
            ADD_ACC64:  add_sel = acc;
            default:    add_sel = '0;
        endcase
        sum = prod + add_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            wide_q <= 1'b0;
            res_q  <= '0;
        end else if (en) begin
            v_q <= in_v;
            if (in_v) begin
                wide_q <= wide;
                res_q  <= wide ? sum : {{(PW-W){1'b0}}, sum[W-1:0]};
            end
        end
    end

    assign res_v = v_q;
    assign res   = res_q;

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (v_q && !en) |=> (v_q && $stable(res_q)));

    // R9
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (v_q && !wide_q) |-> (res_q[PW-1:W] == '0));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [3:0]   op,
    input  logic         is_signed,
    input  logic         sel_a_hi,
    input  logic         sel_b_hi,
    input  logic [31:0]  opa,
    input  logic [31:0]  opb,
    input  logic [31:0]  acc_hi,
    input  logic [31:0]  acc_lo,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [63:0]  out_result
);
    localparam int unsigned W  = MAC_W;
    localparam int unsigned PW = 2 * W;

    dec_t              dec;
    logic signed [W:0] xa;
    logic signed [W:0] xb;
    logic [PW-1:0]     prod;
    logic              advance;
    stage1_t           s1_q;

    assign dec       = mac_decode(op);
    assign advance   = !(out_valid && !out_ready);
    assign in_ready  = advance;

    mac_opnd_sel #(.W(W)) u_sel (
        .shape    (dec.shape),
        .use_sign (dec.use_sign & is_signed),
        .sel_a_hi (sel_a_hi),
        .sel_b_hi (sel_b_hi),
        .a        (opa),
        .b        (opb),
        .xa       (xa),
        .xb       (xb)
    );

    mac_mult #(.W(W)) u_mult (
        .shape (dec.shape),
        .xa    (xa),
        .xb    (xb),
        .prod  (prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else if (advance) begin
            s1_q.valid <= in_valid;
            if (in_valid) begin
                s1_q.half   <= (dec.shape == SHP_HALF);
                s1_q.addend <= dec.addend;
                s1_q.wide   <= dec.wide;
                s1_q.prod   <= prod;
                s1_q.acc    <= {acc_hi, acc_lo};
            end
        end
    end

    mac_accum #(.W(W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (advance),
        .in_v   (s1_q.valid),
        .addend (s1_q.addend),
        .wide   (s1_q.wide),
        .prod   (s1_q.prod),
        .acc    (s1_q.acc),
        .res_v  (out_valid),
        .res    (out_result)
    );

    // R10
    accept_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> s1_q.valid);

    // R10
    second_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && in_ready) |=> out_valid);

    // R6
    half_range_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.half) |->
            ($countones(s1_q.prod[PW-1:W-1]) == 0 || $countones(s1_q.prod[PW-1:W-1]) == W + 1));

endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  op = '0;
    logic        is_signed = 1'b0;
    logic        sel_a_hi = 1'b0;
    logic        sel_b_hi = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] acc_hi = '0;
    logic [31:0] acc_lo = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;
    logic [63:0] prev_ref = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    mac_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .op(op), .is_signed(is_signed), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
        .opa(opa), .opb(opb), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1, 4'd6, 4'd9: return "R4";
            4'd2, 4'd7, 4'd10: return "R5";
            4'd3: return "R2";
            4'd4: return "R3";
            4'd5: return "R6";
            4'd8: return "R7";
            4'd11: return "R8";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [63:0] lo32(input logic [63:0] v);
        return {32'd0, v[31:0]};
    endfunction

    function automatic logic [63:0] model(input logic [3:0] o, input bit sg, input bit ah, input bit bh,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] hi, input logic [31:0] lo,
                                          input logic [63:0] prev);
        logic [15:0] ha, hb;
        longint hp, wp, sp;
        logic [63:0] up, fp, acc64;
        ha = ah ? a[31:16] : a[15:0];
        hb = bh ? b[31:16] : b[15:0];
        hp = longint'($signed(ha)) * longint'($signed(hb));
        wp = longint'($signed(a)) * longint'($signed(hb));
        wp = wp >>> 16;
        sp = longint'($signed(a)) * longint'($signed(b));
        up = {32'd0, a} * {32'd0, b};
        fp = sg ? 64'(sp) : up;
        acc64 = {hi, lo};
        case (o)
            4'd0:  return lo32(up);
            4'd1:  return lo32(up + 64'(lo));
            4'd2:  return lo32(up + 64'(prev[31:0]));
            4'd3:  return fp;
            4'd4:  return fp + acc64;
            4'd5:  return lo32(64'(hp));
            4'd6:  return lo32(64'(hp) + 64'(lo));
            4'd7:  return lo32(64'(hp) + 64'(prev[31:0]));
            4'd8:  return lo32(64'(wp));
            4'd9:  return lo32(64'(wp) + 64'(lo));
            4'd10: return lo32(64'(wp) + 64'(prev[31:0]));
            4'd11: return 64'(hp) + acc64;
            default: return 64'd0;
        endcase
    endfunction

    task automatic issue(input logic [3:0] o, input bit sg, input bit ah, input bit bh,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] hi, input logic [31:0] lo);
        logic [63:0] e;
        do @(negedge clk); while (!in_ready);
        op = o; is_signed = sg; sel_a_hi = ah; sel_b_hi = bh;
        opa = a; opb = b; acc_hi = hi; acc_lo = lo;
        in_valid = 1'b1;
        e = model(o, sg, ah, bh, a, b, hi, lo, prev_ref);
        prev_ref = e;
        exp_q.push_back(e);
        tag_q.push_back(op_tag(o));
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // result scoreboard: compares every delivered result in issue order (R10)
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", out_result, 64'd0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_result == e, t, out_result, e);
                if (e[63:32] == 32'd0 && t != "R2" && t != "R3" && t != "R8")
                    check(out_result[63:32] == 32'd0, "R9", out_result, e);
            end
        end
    end

    logic [31:0] pat[8] = '{32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff, 32'h0000_0000,
                            32'h0000_0001, 32'h8000_8000, 32'h7fff_8000, 32'h0001_7fff};

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R13 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R13 in_ready", 64'(in_ready), 64'd1);

        // R13 / R5: previous result is zero after reset
        issue(4'd2, 1'b0, 1'b0, 1'b0, 32'd3, 32'd5, 32'd0, 32'd0);

        // R10: exact two-edge latency from an idle pipeline
        repeat (4) @(negedge clk);
        issue(4'd0, 1'b0, 1'b0, 1'b0, 32'd7, 32'd9, 32'd0, 32'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 early", 64'(out_valid), 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R10 on time", 64'(out_valid), 64'd1);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 single cycle", 64'(out_valid), 64'd0);

        // extreme-value sweep of all opcodes, signedness and half selects (R1-R8, R12)
        for (int o = 0; o < 16; o++)
            for (int s = 0; s < 8; s++)
                for (int i = 0; i < 8; i++)
                    issue(4'(o), s[0], s[1], s[2], pat[i], pat[(i + s + 3) % 8],
                          pat[(i + 5) % 8], pat[(i + o) % 8]);

        // R5: chained accumulation through previous results
        for (int i = 0; i < 20; i++)
            issue(4'(2 + (i % 3) * 5 - ((i % 3) == 2 ? 2 : 0)), 1'b0, i[0], i[1],
                  $urandom, $urandom, $urandom, $urandom);

        // random mix
        for (int i = 0; i < 400; i++)
            issue(4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom), 1'($urandom),
                  $urandom, $urandom, $urandom, $urandom);

        // R11: output stall holds result and blocks input
        repeat (4) @(negedge clk);
        @(posedge clk); #1 out_ready = 1'b0;
        issue(4'd3, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0);
        issue(4'd4, 1'b0, 1'b0, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff);
        @(negedge clk);
        begin
            logic [63:0] held;
            held = out_result;
            check(out_valid == 1'b1, "R11 valid", 64'(out_valid), 64'd1);
            check(held == 64'h4000_0000_0000_0000, "R11 value", held, 64'h4000_0000_0000_0000);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(out_valid == 1'b1, "R11 valid held", 64'(out_valid), 64'd1);
                check(out_result == held, "R11 result held", out_result, held);
                check(in_ready == 1'b0, "R11 in_ready", 64'(in_ready), 64'd0);
            end
        end
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R10 all delivered", 64'(exp_q.size()), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule